// File: doc/BRIEF.md
# Event-Driven PWM Action Generator

This block makes one PWM output from a 16-bit counter and a small table of actions. The counter either counts down and reloads, or counts up to a load value and back down to zero. As it runs, it raises six events: reaching zero, reaching the load value, matching compare value A, and matching compare value B. Each compare match is split by the counting direction. Every event has a 2-bit action in the table, and that action holds, toggles, clears or sets the output register.

Software writes the table through a one-cycle write port. An update-mode input decides when a written table is used. In immediate mode it is used at once. In local mode it is used at the next counter zero. In global mode it is used at the first counter zero after a global sync request has been recorded. When several events happen in the same cycle, a fixed priority picks exactly one action.

Top module: `pwm_action_gen`

## Requirements
- R1: After reset the output is 0, the count is 0, the direction is up (`cntDown`=0) and every action field is 0. With no table write, the output stays 0.
- R2: When `upDownMode`=0 and the counter is enabled, a count of 0 reloads `loadValue` on the next cycle. Any other count decrements by 1. `cntDown` reads 1.
- R3: When `upDownMode`=1, the counter steps up by 1 until it equals `loadValue`, then steps down by 1 until it reaches 0, then steps up again. `cntDown` is 1 only while counting down.
- R4: Events are decoded from the current count while the counter is enabled:
  - zero when the count is 0;
  - load when the count equals `loadValue`;
  - compare A or B when the count equals `cmpAValue` or `cmpBValue`, qualified by `cntDown`.
  In down-only mode the up-direction compare actions never fire.
- R5: The table has six 2-bit fields, numbered from bit 0 upward:
  - bits 1:0 zero;
  - bits 3:2 load;
  - bits 5:4 compare A up;
  - bits 7:6 compare A down;
  - bits 9:8 compare B up;
  - bits 11:10 compare B down.
  The codes are 0 hold, 1 invert, 2 drive low and 3 drive high. The output register changes on the clock edge that ends the event's cycle.
- R6: A zero or load event overrides any compare event in the same cycle, even when its own code is 0. Zero overrides load.
- R7: When compare A and compare B match in the same cycle, only the compare B action is applied.
- R8: With `updMode`=0, a written table drives the events of the very next cycle.
- R9: With `updMode`=1, a written table is held pending and becomes active on the clock edge that ends a zero-event cycle. The zero action of that cycle still uses the old table.
- R10: With `updMode`=2 or 3, a pending table becomes active only at a zero event while a sync request is recorded. A `globalSync` pulse records the request from the next cycle on, and applying the table clears it.
- R11: A second write before a pending table is applied replaces it, so the first value is never used.
- R12: Bits 31:12 of `wrData` have no effect.
- R13: While `cntEnable`=0, the count holds, no event fires and the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntEnable | input | 1 | Run the counter and enable events |
| upDownMode | input | 1 | 0 down-only, 1 up/down |
| loadValue | input | 16 | Reload / turnaround value |
| cmpAValue | input | 16 | Compare value A |
| cmpBValue | input | 16 | Compare value B |
| updMode | input | 2 | 0 immediate, 1 local, 2/3 global |
| globalSync | input | 1 | One-cycle global update request |
| wrEn | input | 1 | Table write strobe |
| wrData | input | 32 | Table write data |
| cntValue | output | 16 | Current count |
| cntDown | output | 1 | Counting direction is down |
| pwmOut | output | 1 | PWM output |

## Verification
The hardest case to reach is a globally synchronised update in which the write, the sync pulse and the counter zero fall in different orders, combined with a second write that must replace the first. The bench sweeps the offset of a write pair across a whole up/down period, in all three update modes, with the sync pulse placed both before and after a zero. This drives every ordering of write, sync and zero. A bench model built from the counter's phase arithmetic predicts the output on every cycle.

// File: rtl/pwm_action_pkg.sv
package pwm_action_pkg;
  localparam int FIELD_W = 2;
  localparam int NUM_EVT = 6;
  localparam int ACT_W   = FIELD_W * NUM_EVT;

  // field index inside the action table (bit position = 2*index)
  localparam int EV_ZERO  = 0;
  localparam int EV_LOAD  = 1;
  localparam int EV_A_UP  = 2;
  localparam int EV_A_DN  = 3;
  localparam int EV_B_UP  = 4;
  localparam int EV_B_DN  = 5;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_FLIP = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_HIGH = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    UPD_NOW    = 2'd0,
    UPD_LOCAL  = 2'd1,
    UPD_GLOBAL = 2'd2,
    UPD_ALT    = 2'd3
  } upd_e;

  typedef struct packed {
    logic zero;
    logic load;
    logic cmpAUp;
    logic cmpADn;
    logic cmpBUp;
    logic cmpBDn;
    logic commitOk;
  } evt_strb_t;
endpackage

// File: rtl/pwm_evt_ctrl.sv
module pwm_evt_ctrl
  import pwm_action_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEnable,
  input  logic             upDownMode,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] cmpAValue,
  input  logic [CNT_W-1:0] cmpBValue,
  input  logic [1:0]       updMode,
  input  logic             globalSync,
  input  logic             commitDone,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntDown,
  output evt_strb_t        strb
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cntNext;
  logic             dirUp, dirUpNext;
  logic             syncPend;
  logic             atZero, atLoad, goingDown;
  upd_e             mode;

  assign mode      = upd_e'(updMode);
  assign atZero    = (cnt == CNT_ZERO);
  assign atLoad    = (cnt == loadValue);
  assign goingDown = !upDownMode || !dirUp;

  // next count and direction
  always_comb begin
    cntNext   = cnt;
    dirUpNext = dirUp;
    if (!upDownMode) begin
      dirUpNext = 1'b0;
      cntNext   = atZero ? loadValue : cnt - CNT_ONE;
    end else if (dirUp) begin
      if (cnt >= loadValue) begin
        dirUpNext = 1'b0;
        cntNext   = atZero ? CNT_ZERO : cnt - CNT_ONE;
      end else begin
        cntNext = cnt + CNT_ONE;
      end
    end else begin
      if (atZero) begin
        dirUpNext = 1'b1;
        cntNext   = (loadValue == CNT_ZERO) ? CNT_ZERO : CNT_ONE;
      end else begin
        cntNext = cnt - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CNT_ZERO;
      dirUp <= 1'b1;
    end else if (cntEnable) begin
      cnt   <= cntNext;
      dirUp <= dirUpNext;
    end
  end

  // global sync request flag: cleared by an applied update, a new pulse wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncPend <= 1'b0;
    end else begin
      if (commitDone) syncPend <= 1'b0;
      if (globalSync) syncPend <= 1'b1;
    end
  end

  // event strobes towards the datapath
  always_comb begin
    strb.zero   = cntEnable && atZero;
    strb.load   = cntEnable && atLoad;
    strb.cmpAUp = cntEnable && (cnt == cmpAValue) && !goingDown;
    strb.cmpADn = cntEnable && (cnt == cmpAValue) &&  goingDown;
    strb.cmpBUp = cntEnable && (cnt == cmpBValue) && !goingDown;
    strb.cmpBDn = cntEnable && (cnt == cmpBValue) &&  goingDown;
    unique case (mode)
      UPD_NOW:   strb.commitOk = 1'b0;
      UPD_LOCAL: strb.commitOk = strb.zero;
      default:   strb.commitOk = strb.zero && syncPend;
    endcase
  end

  assign cntValue = cnt;
  assign cntDown  = goingDown;
endmodule

// File: rtl/pwm_act_dp.sv
module pwm_act_dp
  import pwm_action_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evt_strb_t        strb,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       updMode,
  output logic             pwmOut,
  output logic [ACT_W-1:0] activeTbl,
  output logic             commitDone
);
  logic [ACT_W-1:0] pendTbl;
  logic             pendValid;
  act_e             fld [NUM_EVT];
  act_e             chosen;
  logic             outNext;
  logic             unusedHiBits;

  assign unusedHiBits = ^wrData[REG_W-1:ACT_W];
  assign commitDone   = pendValid && strb.commitOk && !wrEn;

  // table buffering
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeTbl <= '0;
      pendTbl   <= '0;
      pendValid <= 1'b0;
    end else if (wrEn) begin
      if (upd_e'(updMode) == UPD_NOW) begin
        activeTbl <= wrData[ACT_W-1:0];
        pendValid <= 1'b0;
      end else begin
        pendTbl   <= wrData[ACT_W-1:0];
        pendValid <= 1'b1;
      end
    end else if (commitDone) begin
      activeTbl <= pendTbl;
      pendValid <= 1'b0;
    end
  end

  // split the table into per-event fields
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_fld
    assign fld[g] = act_e'(activeTbl[FIELD_W*g +: FIELD_W]);
  end

  // fixed priority: zero, load, compare B, compare A
  always_comb begin
    if (strb.zero)        chosen = fld[EV_ZERO];
    else if (strb.load)   chosen = fld[EV_LOAD];
    else if (strb.cmpBDn) chosen = fld[EV_B_DN];
    else if (strb.cmpBUp) chosen = fld[EV_B_UP];
    else if (strb.cmpADn) chosen = fld[EV_A_DN];
    else if (strb.cmpAUp) chosen = fld[EV_A_UP];
    else                  chosen = ACT_HOLD;
  end

  always_comb begin
    unique case (chosen)
      ACT_HOLD: outNext = pwmOut;
      ACT_FLIP: outNext = !pwmOut;
      ACT_LOW:  outNext = 1'b0;
      ACT_HIGH: outNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwmOut <= 1'b0;
    else        pwmOut <= outNext;
  end
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
  import pwm_action_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEnable,
  input  logic             upDownMode,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] cmpAValue,
  input  logic [CNT_W-1:0] cmpBValue,
  input  logic [1:0]       updMode,
  input  logic             globalSync,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntDown,
  output logic             pwmOut
);
  evt_strb_t        evStrb;
  logic             commitDone;
  logic [ACT_W-1:0] activeTbl;

  pwm_evt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .upDownMode(upDownMode),
    .loadValue(loadValue), .cmpAValue(cmpAValue), .cmpBValue(cmpBValue),
    .updMode(updMode), .globalSync(globalSync), .commitDone(commitDone),
    .cntValue(cntValue), .cntDown(cntDown), .strb(evStrb)
  );

  pwm_act_dp #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(evStrb), .wrEn(wrEn), .wrData(wrData),
    .updMode(updMode), .pwmOut(pwmOut), .activeTbl(activeTbl),
    .commitDone(commitDone)
  );
endmodule

// File: rtl/pwm_action_gen_chk.sv
module pwm_action_gen_chk
  import pwm_action_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cntEnable,
  input logic             upDownMode,
  input logic [CNT_W-1:0] loadValue,
  input logic [1:0]       updMode,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [CNT_W-1:0] cntValue,
  input logic             cntDown,
  input logic             pwmOut,
  input evt_strb_t        strb,
  input logic [ACT_W-1:0] activeTbl
);
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cntEnable && !upDownMode && cntValue == '0 |=> cntValue == $past(loadValue)); // R2

  AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !upDownMode |-> cntDown); // R2

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    strb.zero && activeTbl[1:0] == 2'd3 |=> pwmOut); // R5

  AST_ZERO_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.zero && activeTbl[1:0] == 2'd0 |=> $stable(pwmOut)); // R6

  AST_CMPB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cmpBDn && strb.cmpADn && !strb.zero && !strb.load && activeTbl[11:10] == 2'd2
    |=> !pwmOut); // R7

  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && updMode == 2'd0 |=> activeTbl == $past(wrData[ACT_W-1:0])); // R8

  AST_TBL_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && updMode == 2'd0) && !strb.zero |=> $stable(activeTbl)); // R9

  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cntEnable |=> $stable(cntValue) && $stable(pwmOut)); // R13
endmodule

bind pwm_action_gen pwm_action_gen_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .upDownMode(upDownMode),
  .loadValue(loadValue), .updMode(updMode), .wrEn(wrEn), .wrData(wrData),
  .cntValue(cntValue), .cntDown(cntDown), .pwmOut(pwmOut), .strb(evStrb),
  .activeTbl(activeTbl)
);

// File: tb/pwm_action_gen_bench.sv
module pwm_action_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntEnable = 1'b0;
  logic        upDownMode = 1'b0;
  logic [15:0] loadValue = 16'd6;
  logic [15:0] cmpAValue = 16'd2;
  logic [15:0] cmpBValue = 16'd4;
  logic [1:0]  updMode = 2'd0;
  logic        globalSync = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [15:0] cntValue;
  logic        cntDown;
  logic        pwmOut;

  int nChecks = 0;
  int nErrors = 0;
  string curReq = "R1";
  string cntReq = "R2";

  always #10 clk = ~clk;

  pwm_action_gen u_pwm_action_gen (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .upDownMode(upDownMode),
    .loadValue(loadValue), .cmpAValue(cmpAValue), .cmpBValue(cmpBValue),
    .updMode(updMode), .globalSync(globalSync), .wrEn(wrEn), .wrData(wrData),
    .cntValue(cntValue), .cntDown(cntDown), .pwmOut(pwmOut)
  );

  // phase-based reference model
  int         mP;
  logic [11:0] mAct, mPend;
  logic       mPendV, mSync, mOut;

  function automatic int mCnt();
    int l = int'(loadValue);
    if (!upDownMode) return (mP == 0) ? 0 : l + 1 - mP;
    return (mP <= l) ? mP : 2 * l - mP;
  endfunction

  function automatic logic mDown();
    return !upDownMode || (mP > int'(loadValue));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mP = 0; mAct = '0; mPend = '0; mPendV = 1'b0; mSync = 1'b0; mOut = 1'b0;
    end else begin
      int c, l, idx;
      logic z, ld, a, b, dn, okCommit, cd;
      logic [1:0] code;
      l  = int'(loadValue);
      c  = mCnt();
      dn = mDown();
      z  = cntEnable && c == 0;
      ld = cntEnable && c == l;
      a  = cntEnable && c == int'(cmpAValue);
      b  = cntEnable && c == int'(cmpBValue);
      idx = -1;
      if (z) idx = 0;
      else if (ld) idx = 1;
      else if (b) idx = dn ? 5 : 4;
      else if (a) idx = dn ? 3 : 2;
      code = (idx < 0) ? 2'd0 : mAct[2*idx +: 2];
      case (code)
        2'd1: mOut = !mOut;
        2'd2: mOut = 1'b0;
        2'd3: mOut = 1'b1;
        default: ;
      endcase
      okCommit = z && (updMode == 2'd1 || (updMode >= 2'd2 && mSync));
      cd = mPendV && okCommit && !wrEn;
      if (wrEn) begin
        if (updMode == 2'd0) begin mAct = wrData[11:0]; mPendV = 1'b0; end
        else begin mPend = wrData[11:0]; mPendV = 1'b1; end
      end else if (cd) begin
        mAct = mPend; mPendV = 1'b0;
      end
      if (cd) mSync = 1'b0;
      if (globalSync) mSync = 1'b1;
      if (cntEnable) begin
        if (!upDownMode) mP = (mP >= l) ? 0 : mP + 1;
        else             mP = (mP >= 2 * l - 1) ? 0 : mP + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(pwmOut == mOut, curReq, int'(pwmOut), int'(mOut));
    chk(int'(cntValue) == mCnt(), cntReq, int'(cntValue), mCnt());
    if (mCnt() != 0)
      chk(cntDown == mDown(), cntReq, int'(cntDown), int'(mDown()));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doReset(input logic ud, input int l, input int ca, input int cb);
    @(negedge clk);
    rst_n = 1'b0; cntEnable = 1'b0; wrEn = 1'b0; globalSync = 1'b0;
    upDownMode = ud; loadValue = 16'(l); cmpAValue = 16'(ca); cmpBValue = 16'(cb);
    cntReq = ud ? "R3" : "R2";
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwmOut == 1'b0 && cntValue == 16'd0 && cntDown == !ud, "R1",
        int'({pwmOut, cntValue == 16'd0, cntDown}), int'({1'b0, 1'b1, !ud}));
    cntEnable = 1'b1;
  endtask

  task automatic wr(input logic [31:0] v);
    wrData = v; wrEn = 1'b1; tick(); wrEn = 1'b0;
  endtask

  task automatic pulseSync();
    globalSync = 1'b1; tick(); globalSync = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    // R1: all-zero table keeps the output low
    curReq = "R1";
    doReset(1'b1, 6, 2, 4);
    run(30);

    // R5 / R4: every field, every non-hold code, both counting modes
    for (int md = 0; md < 2; md++)
      for (int f = 0; f < 6; f++)
        for (int code = 1; code < 4; code++) begin
          curReq = (md == 0 && (f == 2 || f == 4)) ? "R4" : "R5";
          doReset(md[0], 6, 2, 4);
          updMode = 2'd0;
          wr(32'(code) << (2 * f));
          run(28);
        end

    // R6: load with hold code beats compare A; zero with hold beats compare B
    curReq = "R6";
    doReset(1'b1, 6, 6, 0);
    wr(32'h0000_0C30);
    run(30);
    // R6: zero over load when the load value is 0
    doReset(1'b0, 0, 3, 3);
    wr(32'h0000_0003 | 32'h0000_0008);
    run(10);
    wr(32'h0000_0002 | 32'h0000_000C);
    run(10);

    // R7: compare B over compare A at the same count
    curReq = "R7";
    for (int md = 0; md < 2; md++) begin
      doReset(md[0], 7, 3, 3);
      wr(32'h0000_05A0);
      run(32);
    end

    // R8..R11: write pairs at every offset in every update mode
    for (int um = 0; um < 3; um++)
      for (int off = 0; off < 11; off++) begin
        curReq = (um == 0) ? "R8" : (um == 1) ? "R9" : "R10";
        doReset(1'b1, 5, 2, 4);
        updMode = 2'(um);
        run(off);
        if (off % 3 == 0) pulseSync();
        wr(32'h0000_000B);
        curReq = "R11";
        wr(32'h0000_0410 | 32'h0000_000E);
        run(off % 4);
        if (off % 3 != 0) pulseSync();
        curReq = (um == 2) ? "R10" : "R11";
        run(24);
        if (um == 2) begin
          wr(32'h0000_000B);
          run(14);
          pulseSync();
          run(14);
        end
      end

    // R12: upper write bits ignored
    curReq = "R12";
    doReset(1'b1, 6, 2, 4);
    wr(32'hFFFF_F000);
    run(26);
    wr(32'hA5A5_A000 | 32'h0000_0017);
    run(26);

    // R13: counter disabled holds count and output
    curReq = "R13";
    cntReq = "R13";
    doReset(1'b1, 6, 2, 4);
    wr(32'h0000_0555);
    run(5);
    cntEnable = 1'b0;
    run(9);
    cntEnable = 1'b1;
    run(10);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule